// File: doc/BRIEF.md
# Byte-to-Nibble ADPCM Feeder

This block sits between a parallel host port and a 4-bit ADPCM decoder. The host puts a byte on its data lines and pulses a strobe. The feeder captures the byte and raises a busy flag. It then hands the decoder two 4-bit codes, one for each of two consecutive sample-clock periods: the upper half of the byte first, then the lower half. The sample clock is a level signal that runs slower than the system clock. All inputs are synchronous to the system clock `clk`.

Busy stays high until the second code has been moved onto the nibble output. This frees the capture register, so the host can load the next byte during the low-half period and the stream has no gaps. A host reset forces the decoder reset at once. The decoder reset is released only at a sample-clock rising edge.

A sequencer with four states paces the codes:

- `ST_RST`: the decoder is held in reset.
- `ST_IDLE`: no byte is pending, and a zero code is presented.
- `ST_HIGH`: the upper half is presented.
- `ST_LOW`: the lower half is presented.

Transitions happen only on a sample edge, except the forced entry into `ST_RST`:

| Transition | Condition |
|---|---|
| any state → `ST_RST` | host reset is high |
| `ST_RST` → `ST_IDLE` | sample edge with host reset low |
| `ST_IDLE` / `ST_LOW` → `ST_HIGH` | sample edge while a byte is pending |
| `ST_IDLE` / `ST_LOW` → `ST_IDLE` | sample edge with nothing pending |
| `ST_HIGH` → `ST_LOW` | sample edge |

Top module: `nibble_feeder`

## Requirements
- R1: While `rst_n` is low, `busy` reads 0, `nibble` reads 0 and `dec_reset` reads 1.
- R2: When `host_reset` is high at a `clk` edge, `dec_reset` is 1 after that edge.
- R3: `dec_reset` falls only at the first `clk` edge that sees a rising edge of `sample_clk` while `host_reset` is low. Before that edge it stays 1.
- R4: When `host_strobe` rises (0 in the previous cycle, 1 now) while `busy` and `dec_reset` are both 0, the byte on `host_data` is captured and `busy` is 1 after that edge.
- R5: A rising strobe while `busy` is 1 is ignored. The captured byte keeps its value and `busy` stays 1.
- R6: A rising strobe while `dec_reset` is 1 or `host_reset` is 1 is ignored, and `busy` stays 0.
- R7: At the first sample edge after a capture, `nibble` takes bits [7:4] of the captured byte.
- R8: At the next sample edge, `nibble` takes bits [3:0] of the same byte, and `busy` returns to 0 at that same edge.
- R9: A sample edge that ends an idle or low-half period with no byte pending sets `nibble` to 0.
- R10: Whenever `dec_reset` is 1, `nibble` is 0.
- R11: `nibble` changes only at a sample edge or on a host reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_data | input | 8 | Byte from the host |
| host_strobe | input | 1 | Host strobe; a rising edge offers a byte |
| host_reset | input | 1 | Host request to reset the decoder, active high |
| sample_clk | input | 1 | Decoder sample clock, as a level; its rising edge marks a code boundary |
| busy | output | 1 | High while a captured byte has not been fully handed over |
| nibble | output | 4 | ADPCM code presented to the decoder |
| dec_reset | output | 1 | Decoder reset, active high |

## Verification
The hardest case to reach is a back-to-back stream: the next byte must arrive during the low-half period, so that the sample edge leaving `ST_LOW` goes straight to `ST_HIGH` instead of through `ST_IDLE`. The bench strobes each new byte right after the sample edge that frees the register. It sweeps all 256 byte values this way, and inserts an ignored strobe during every high-half period. It also asserts host reset in the middle of a byte, to confirm that the pending byte is dropped and that release waits for a sample edge.

// File: rtl/nibble_feeder_pkg.sv
package nibble_feeder_pkg;

    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_IDLE = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } feed_state_t;

endpackage

// File: rtl/nf_rise_detect.sv
module nf_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/nf_byte_latch.sv
module nf_byte_latch #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              rel_i,
    input  logic              clr_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              full_o
);
    logic [BYTE_W-1:0] data_q;
    logic              full_q;
    logic              take;

    assign take = cap_i & ~full_q & ~clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (clr_i) begin
            full_q <= 1'b0;
        end else if (take) begin
            data_q <= data_i;
            full_q <= 1'b1;
        end else if (rel_i) begin
            full_q <= 1'b0;
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;

    assert_hold_while_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !clr_i) |=> $stable(data_q));
    assert_cleared_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !full_q);
endmodule

// File: rtl/nf_sequencer.sv
module nf_sequencer
    import nibble_feeder_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                host_reset_i,
    input  logic                full_i,
    input  logic [BYTE_W-1:0]   byte_i,
    output logic [BYTE_W/2-1:0] nib_o,
    output logic                dec_reset_o,
    output logic                release_o,
    output logic                in_reset_o
);
    localparam int NIB_W = BYTE_W / 2;

    feed_state_t      state_q, state_d;
    logic [NIB_W-1:0] nib_q;

    always_comb begin
        state_d = state_q;
        if (host_reset_i) begin
            state_d = ST_RST;
        end else if (tick_i) begin
            unique case (state_q)
                ST_RST:          state_d = ST_IDLE;
                ST_IDLE, ST_LOW: state_d = full_i ? ST_HIGH : ST_IDLE;
                ST_HIGH:         state_d = ST_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_q <= '0;
        end else if (host_reset_i) begin
            nib_q <= '0;
        end else if (tick_i) begin
            unique case (state_d)
                ST_HIGH: nib_q <= byte_i[BYTE_W-1:NIB_W];
                ST_LOW:  nib_q <= byte_i[NIB_W-1:0];
                default: nib_q <= '0;
            endcase
        end
    end

    assign nib_o       = nib_q;
    assign dec_reset_o = (state_q == ST_RST);
    assign release_o   = tick_i & ~host_reset_i & (state_q == ST_HIGH);
    assign in_reset_o  = host_reset_i | (state_q == ST_RST);

    assert_reset_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset_i |=> dec_reset_o);
    assert_release_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_reset_o) |-> $past(tick_i && !host_reset_i));
    assert_high_has_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> full_i);
    assert_silent_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_reset_o |-> (nib_o == '0));
    assert_hold_between_edges_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !host_reset_i) |=> $stable(nib_o));
endmodule

// File: rtl/nibble_feeder.sv
module nibble_feeder #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   host_data,
    input  logic                host_strobe,
    input  logic                host_reset,
    input  logic                sample_clk,
    output logic                busy,
    output logic [BYTE_W/2-1:0] nibble,
    output logic                dec_reset
);
    logic              strobe_rise;
    logic              sample_rise;
    logic              rel;
    logic              in_reset;
    logic              full;
    logic [BYTE_W-1:0] held;

    nf_rise_detect u_strobe_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (host_strobe),
        .rise_o  (strobe_rise)
    );

    nf_rise_detect u_sample_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sample_clk),
        .rise_o  (sample_rise)
    );

    nf_byte_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (strobe_rise),
        .rel_i  (rel),
        .clr_i  (in_reset),
        .data_i (host_data),
        .data_o (held),
        .full_o (full)
    );

    nf_sequencer #(.BYTE_W(BYTE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (sample_rise),
        .host_reset_i (host_reset),
        .full_i       (full),
        .byte_i       (held),
        .nib_o        (nibble),
        .dec_reset_o  (dec_reset),
        .release_o    (rel),
        .in_reset_o   (in_reset)
    );

    assign busy = full;

    assert_busy_drops_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(sample_rise || host_reset || dec_reset));
endmodule

// File: tb/nibble_feeder_tb.sv
module nibble_feeder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_strobe = 1'b0;
    logic       host_reset = 1'b1;
    logic       sample_clk = 1'b0;
    logic       busy;
    logic [3:0] nibble;
    logic       dec_reset;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nibble_feeder u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data   (host_data),
        .host_strobe (host_strobe),
        .host_reset  (host_reset),
        .sample_clk  (sample_clk),
        .busy        (busy),
        .nibble      (nibble),
        .dec_reset   (dec_reset)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] b);
        @(negedge clk);
        host_data   = b;
        host_strobe = 1'b1;
        @(negedge clk);
        host_strobe = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_clk = 1'b1;
        @(negedge clk);
        sample_clk = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 nibble", nibble, 0);
        chk("R1 dec_reset", dec_reset, 1);
        rst_n = 1'b1;

        tick();
        chk("R3 held while host reset", dec_reset, 1);
        strobe(8'hA5);
        chk("R6 strobe in reset", busy, 0);

        @(negedge clk);
        host_reset = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 no edge yet", dec_reset, 1);
        strobe(8'h3C);
        chk("R6 strobe before release", busy, 0);
        tick();
        chk("R3 released at edge", dec_reset, 0);
        chk("R10 nibble after release", nibble, 0);

        tick();
        chk("R9 idle zero", nibble, 0);

        // Stream every byte value back to back.
        for (int b = 0; b < 256; b++) begin
            automatic int prev = nibble;
            strobe(b[7:0]);
            chk("R4 busy on capture", busy, 1);
            chk("R11 nibble stable on strobe", nibble, prev);
            tick();
            chk("R7 high half", nibble, (b >> 4) & 15);
            strobe(~b[7:0]);
            chk("R5 busy kept", busy, 1);
            tick();
            chk("R8 low half", nibble, b & 15);
            chk("R8 busy dropped", busy, 0);
        end
        tick();
        chk("R9 zero after stream", nibble, 0);
        chk("R9 busy low", busy, 0);

        // Host reset in the middle of a byte.
        strobe(8'h96);
        tick();
        chk("R7 high before reset", nibble, 9);
        @(negedge clk);
        host_reset = 1'b1;
        @(negedge clk);
        chk("R2 dec_reset forced", dec_reset, 1);
        chk("R10 nibble cleared", nibble, 0);
        chk("R6 byte dropped", busy, 0);
        host_reset = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 wait for edge", dec_reset, 1);
        tick();
        chk("R3 released again", dec_reset, 0);
        strobe(8'h71);
        tick();
        chk("R7 after reset", nibble, 7);
        tick();
        chk("R8 after reset", nibble, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule